// File: doc/BRIEF.md
# Latency-Measuring Dual-Clock FIFO

This block carries wide PCS words from a fabric-side PMA clock domain into the transceiver PMA clock domain. It holds them in a 16-entry buffer, and the two pointers cross between the domains as Gray code through two-flop synchronizers. A link that must have a fixed and known latency also needs to know how long each word waits in the buffer. The block therefore reports a coarse occupancy figure in the write domain, and it reports a finer figure taken in a third, free-running measurement clock domain.

In the measurement domain both pointers are synchronized again, and the difference between them is added to an accumulator on every measurement cycle. After a programmable number N of samples, the total is presented with a one-cycle valid strobe and the accumulator starts again from zero. The measurement clock is unrelated to the other two clocks, so the average over the window resolves the buffer delay to a fraction of a word period. N arrives from any domain, and it is synchronized into the measurement domain before use.

Top module: `lmf_fifo_top`

## Requirements
- R1: While reset is applied and just after it is released: `rd_empty`=1, `wr_full`=0, `wr_level`=0, `acc_valid`=0 and `acc_sum`=0.
- R2: Words leave in the order they were written. Whenever `rd_empty` is 0, `rd_data` shows the oldest stored word, and a `rd_en` on a `rd_clk` edge removes that word.
- R3: After 16 words are written with no reads, `wr_full` is 1 and `wr_level` is 16. A write while `wr_full` is 1 stores nothing, and `wr_full` can only rise after an accepted write.
- R4: A read while `rd_empty` is 1 is ignored. The read pointer does not move, so the next word written is the next word read.
- R5: `wr_level` counts the stored words as seen in the write domain. It rises at the same `wr_clk` edge that accepts a write, and it reflects reads within four `wr_clk` edges.
- R6: `rd_empty` returns to 1 at the `rd_clk` edge that removes the last word. After a write into an empty buffer, `rd_empty` drops within four `rd_clk` edges, and never through a local read.
- R7: While N is nonzero, each `meas_clk` cycle adds the sampled occupancy to the accumulator. After N samples, `acc_sum` takes the window total, `acc_valid` is 1 for exactly that cycle, and the accumulator clears. With a static occupancy k, `acc_sum` equals N*k.
- R8: A new value of `win_size` takes effect only at a window boundary. The first total after a change is either a whole old-N window or a whole new-N window, never a mixture of the two.
- R9: When N is 0 the accumulator stays idle: `acc_valid` is never asserted and `acc_sum` keeps its last value. A later nonzero N starts windows again.
- R10: `acc_sum` changes only in a cycle in which `acc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fabric-side PMA clock (write domain) |
| rd_clk | input | 1 | Transceiver PMA clock (read domain) |
| meas_clk | input | 1 | Free-running measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| wr_en | input | 1 | Write request, `wr_clk` domain |
| wr_data | input | DATA_W (80) | Word to store |
| wr_full | output | 1 | Buffer full, `wr_clk` domain |
| wr_level | output | ADDR_W+1 (5) | Stored words as seen in the write domain |
| rd_en | input | 1 | Read request, `rd_clk` domain |
| rd_data | output | DATA_W (80) | Oldest stored word (show-ahead) |
| rd_empty | output | 1 | Buffer empty, `rd_clk` domain |
| win_size | input | WIN_W (16) | Window length N in samples; 0 stops measurement |
| acc_sum | output | WIN_W+ADDR_W+1 (21) | Total of the last completed window |
| acc_valid | output | 1 | One-cycle strobe marking a new `acc_sum` |

## Verification
A window boundary can land in the same measurement cycle in which the synchronized window length changes. Both effects then compete for the window register.

The bench sets up a static occupancy and lets windows of one length run. It then rewrites `win_size` while a window is in progress, without aligning the change to a boundary. The first total after the change must equal a whole window of either the old length or the new length, and every total after it must match the new length. A mixed value shows that the change reached a window in progress.

// File: rtl/lmf_pkg.sv
`timescale 1ns/1ps
package lmf_pkg;
    localparam int LMF_DATA_W = 80;
    localparam int LMF_ADDR_W = 4;
    localparam int LMF_WIN_W  = 16;
    localparam int LMF_SYNC_STAGES = 2;

    typedef enum logic [0:0] {
        MEAS_IDLE = 1'b0,
        MEAS_RUN  = 1'b1
    } meas_mode_e;
endpackage

// File: rtl/lmf_sync.sv
`timescale 1ns/1ps
module lmf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // chain of flops; oldest stage drives the output
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lmf_gray2bin.sv
`timescale 1ns/1ps
module lmf_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[W-1:i];
    end
endmodule

// File: rtl/lmf_ptr_ctl.sv
`timescale 1ns/1ps
module lmf_ptr_ctl #(
    parameter int ADDR_W   = 4,
    parameter bit IS_WRITE = 1'b1,
    localparam int PW      = ADDR_W + 1,
    localparam int DEPTH   = 1 << ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [PW-1:0] far_gray_i,
    output logic [PW-1:0] bin_o,
    output logic [PW-1:0] gray_o,
    output logic          flag_o,
    output logic [PW-1:0] level_o
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_st_t;

    ptr_st_t       st_d, st_q;
    logic [PW-1:0] far_bin;
    logic [PW-1:0] level;
    logic          flag;
    logic          take;

    lmf_gray2bin #(.W(PW)) i_far_conv (
        .gray_i (far_gray_i),
        .bin_o  (far_bin)
    );

    // the side picks which flag guards the local pointer
    if (IS_WRITE) begin : g_wr_side
        assign level = st_q.bin - far_bin;
        assign flag  = (level == PW'(DEPTH));
    end else begin : g_rd_side
        assign level = far_bin - st_q.bin;
        assign flag  = (level == '0);
    end

    always_comb begin
        st_d = st_q;
        take = step_i && !flag;
        if (take) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bin_o   = st_q.bin;
    assign gray_o  = st_q.gray;
    assign flag_o  = flag;
    assign level_o = level;
endmodule

// File: rtl/lmf_meas.sv
`timescale 1ns/1ps
module lmf_meas
    import lmf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WIN_W  = 16,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int HALF  = DEPTH + DEPTH / 2,
    localparam int ACC_W = WIN_W + PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    w_gray_i,
    input  logic [PW-1:0]    r_gray_i,
    input  logic [WIN_W-1:0] win_i,
    output logic [ACC_W-1:0] sum_o,
    output logic             valid_o,
    output meas_mode_e       mode_o
);
    typedef struct packed {
        meas_mode_e       mode;
        logic [WIN_W-1:0] win;
        logic [WIN_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] sum;
        logic             valid;
    } meas_st_t;

    meas_st_t         st_d, st_q;
    logic [PW-1:0]    w_bin, r_bin;
    logic [PW-1:0]    occ_raw, occ;
    logic [ACC_W-1:0] acc_nx;

    lmf_gray2bin #(.W(PW)) i_w_conv (.gray_i(w_gray_i), .bin_o(w_bin));
    lmf_gray2bin #(.W(PW)) i_r_conv (.gray_i(r_gray_i), .bin_o(r_bin));

    always_comb begin
        // pointers arrive through separate synchronizers; clamp skew
        occ_raw = w_bin - r_bin;
        if (occ_raw > PW'(HALF))       occ = '0;
        else if (occ_raw > PW'(DEPTH)) occ = PW'(DEPTH);
        else                           occ = occ_raw;

        acc_nx     = st_q.acc + ACC_W'(occ);
        st_d       = st_q;
        st_d.valid = 1'b0;

        case (st_q.mode)
            MEAS_IDLE: begin
                st_d.cnt = '0;
                st_d.acc = '0;
                if (win_i != '0) begin
                    st_d.win  = win_i;
                    st_d.mode = MEAS_RUN;
                end
            end
            MEAS_RUN: begin
                if (st_q.cnt == st_q.win - 1'b1) begin
                    st_d.sum   = acc_nx;
                    st_d.valid = 1'b1;
                    st_d.acc   = '0;
                    st_d.cnt   = '0;
                    st_d.win   = win_i;
                    if (win_i == '0) st_d.mode = MEAS_IDLE;
                end else begin
                    st_d.acc = acc_nx;
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.mode = MEAS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o   = st_q.sum;
    assign valid_o = st_q.valid;
    assign mode_o  = st_q.mode;
endmodule

// File: rtl/lmf_fifo_top.sv
`timescale 1ns/1ps
module lmf_fifo_top
    import lmf_pkg::*;
#(
    parameter int DATA_W = LMF_DATA_W,
    parameter int ADDR_W = LMF_ADDR_W,
    parameter int WIN_W  = LMF_WIN_W,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int ACC_W = WIN_W + PW
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              meas_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [PW-1:0]     wr_level,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    input  logic [WIN_W-1:0]  win_size,
    output logic [ACC_W-1:0]  acc_sum,
    output logic              acc_valid
);
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] r_gray_w, w_gray_r, w_gray_m, r_gray_m;
    logic [PW-1:0] rd_level;
    logic [WIN_W-1:0] win_m;
    meas_mode_e    meas_mode;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // write side
    lmf_sync #(.W(PW), .STAGES(LMF_SYNC_STAGES)) i_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d_i(r_gray), .q_o(r_gray_w));

    lmf_ptr_ctl #(.ADDR_W(ADDR_W), .IS_WRITE(1'b1)) i_wr_ptr (
        .clk(wr_clk), .rst_n(rst_n), .step_i(wr_en), .far_gray_i(r_gray_w),
        .bin_o(w_bin), .gray_o(w_gray), .flag_o(wr_full), .level_o(wr_level));

    always_ff @(posedge wr_clk) begin
        if (wr_en && !wr_full) mem_q[w_bin[ADDR_W-1:0]] <= wr_data;
    end

    // read side
    lmf_sync #(.W(PW), .STAGES(LMF_SYNC_STAGES)) i_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d_i(w_gray), .q_o(w_gray_r));

    lmf_ptr_ctl #(.ADDR_W(ADDR_W), .IS_WRITE(1'b0)) i_rd_ptr (
        .clk(rd_clk), .rst_n(rst_n), .step_i(rd_en), .far_gray_i(w_gray_r),
        .bin_o(r_bin), .gray_o(r_gray), .flag_o(rd_empty), .level_o(rd_level));

    assign rd_data = mem_q[r_bin[ADDR_W-1:0]];

    // measurement side
    lmf_sync #(.W(PW), .STAGES(LMF_SYNC_STAGES)) i_sync_w2m (
        .clk(meas_clk), .rst_n(rst_n), .d_i(w_gray), .q_o(w_gray_m));
    lmf_sync #(.W(PW), .STAGES(LMF_SYNC_STAGES)) i_sync_r2m (
        .clk(meas_clk), .rst_n(rst_n), .d_i(r_gray), .q_o(r_gray_m));
    lmf_sync #(.W(WIN_W), .STAGES(LMF_SYNC_STAGES)) i_sync_win (
        .clk(meas_clk), .rst_n(rst_n), .d_i(win_size), .q_o(win_m));

    lmf_meas #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_meas (
        .clk(meas_clk), .rst_n(rst_n), .w_gray_i(w_gray_m), .r_gray_i(r_gray_m),
        .win_i(win_m), .sum_o(acc_sum), .valid_o(acc_valid), .mode_o(meas_mode));
endmodule

// File: rtl/lmf_fifo_chk.sv
`timescale 1ns/1ps
module lmf_fifo_chk
    import lmf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int ACC_W  = 21,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             meas_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_full,
    input logic             rd_empty,
    input logic [PW-1:0]    w_bin,
    input logic [PW-1:0]    r_bin,
    input logic [PW-1:0]    rd_level,
    input logic             acc_valid,
    input logic [ACC_W-1:0] acc_sum,
    input meas_mode_e       meas_mode
);
    // R3
    write_blocked_when_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |=> $stable(w_bin));

    // R3
    full_needs_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(wr_full) |-> $past(wr_en));

    // R4
    read_blocked_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty |=> $stable(r_bin));

    // R6
    empty_clears_remotely_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(rd_empty) |-> $stable(r_bin));

    // R6
    rd_level_bounded_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_level <= PW'(DEPTH));

    // R9
    idle_no_strobe_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
        (meas_mode == MEAS_IDLE) |=> !acc_valid);

    // R10
    sum_moves_with_strobe_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
        !$stable(acc_sum) |-> acc_valid);
endmodule

bind lmf_fifo_top lmf_fifo_chk #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) i_lmf_fifo_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .meas_clk  (meas_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .rd_empty  (rd_empty),
    .w_bin     (w_bin),
    .r_bin     (r_bin),
    .rd_level  (rd_level),
    .acc_valid (acc_valid),
    .acc_sum   (acc_sum),
    .meas_mode (meas_mode)
);

// File: tb/test_lmf_fifo_top.sv
`timescale 1ns/1ps
module test_lmf_fifo_top;
    logic        wr_clk = 1'b0, rd_clk = 1'b0, meas_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [79:0] wr_data = '0;
    logic        wr_full, rd_empty, acc_valid;
    logic [4:0]  wr_level;
    logic [79:0] rd_data;
    logic [15:0] win_size = '0;
    logic [20:0] acc_sum;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #10 wr_clk   = ~wr_clk;   // 50 MHz
    always #7  rd_clk   = ~rd_clk;
    always #13 meas_clk = ~meas_clk;

    lmf_fifo_top i_lmf_fifo_top (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .meas_clk(meas_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_level(wr_level),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .win_size(win_size), .acc_sum(acc_sum), .acc_valid(acc_valid));

    // {fill[4:0], N[15:0]}; expected total = fill * N
    localparam logic [20:0] VEC [6] = '{
        {5'd0,  16'd4}, {5'd1,  16'd1}, {5'd5, 16'd7},
        {5'd16, 16'd3}, {5'd9,  16'd20}, {5'd3, 16'd2}
    };

    function automatic logic [79:0] pat(input int k);
        return {16'hBEEF, 64'(k + 1) * 64'h9E37_79B9_7F4A_7C15};
    endfunction

    task automatic cmp(input string req, input logic [79:0] act, input logic [79:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge wr_clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic push(input logic [79:0] d);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [79:0] exp);
        @(negedge rd_clk);
        cmp(req, 80'(rd_empty), 80'd0);
        cmp(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    task automatic next_valid(output logic [20:0] s, output bit ok);
        ok = 1'b0; s = '0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge meas_clk);
            if (acc_valid) begin s = acc_sum; ok = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [20:0] s, s0;
        bit ok;
        int n, fill, hits;

        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge wr_clk);
        cmp("R1 empty in reset", 80'(rd_empty), 80'd1);
        do_reset();
        cmp("R1 empty", 80'(rd_empty), 80'd1);
        cmp("R1 full", 80'(wr_full), 80'd0);
        cmp("R1 level", 80'(wr_level), 80'd0);
        cmp("R1 valid", 80'(acc_valid), 80'd0);
        cmp("R1 sum", 80'(acc_sum), 80'd0);

        // vector table: static occupancy, window total = fill * N (R7)
        for (int v = 0; v < 6; v++) begin
            fill = int'(VEC[v][20:16]);
            n    = int'(VEC[v][15:0]);
            win_size = 16'(n);
            do_reset();
            for (int k = 0; k < fill; k++) push(pat(k));
            cmp("R5 level after writes", 80'(wr_level), 80'(fill));
            repeat (10) @(negedge meas_clk);
            next_valid(s, ok);
            next_valid(s, ok);
            cmp("R7 strobe seen", 80'(ok), 80'd1);
            cmp("R7 window total", 80'(s), 80'(fill * n));
        end

        // R2, R3: fill, overflow attempt, drain in order
        win_size = '0;
        do_reset();
        for (int k = 0; k < 16; k++) push(pat(k));
        cmp("R3 full", 80'(wr_full), 80'd1);
        push(pat(99));
        cmp("R3 level held", 80'(wr_level), 80'd16);
        repeat (4) @(negedge rd_clk);
        for (int k = 0; k < 16; k++) pop_check("R2 order", pat(k));
        cmp("R6 empty after last read", 80'(rd_empty), 80'd1);
        repeat (6) @(negedge rd_clk);
        cmp("R3 overflow word dropped", 80'(rd_empty), 80'd1);
        repeat (5) @(negedge wr_clk);
        cmp("R5 level after drain", 80'(wr_level), 80'd0);
        cmp("R3 full cleared", 80'(wr_full), 80'd0);

        // R4: reads on empty are ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge rd_clk); rd_en = 1'b1;
            @(negedge rd_clk); rd_en = 1'b0;
        end
        push(pat(200));
        repeat (5) @(negedge rd_clk);
        pop_check("R4 next word after empty reads", pat(200));
        cmp("R4 empty again", 80'(rd_empty), 80'd1);
        repeat (5) @(negedge wr_clk);
        cmp("R4 level consistent", 80'(wr_level), 80'd0);

        // R6: empty drops within four read edges
        push(pat(300));
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge rd_clk);
            if (!rd_empty) break;
            hits++;
        end
        cmp("R6 empty drop latency ok", 80'(hits <= 4), 80'd1);
        pop_check("R6 word readable", pat(300));

        // R8: change of N lands on a boundary
        do_reset();
        push(pat(1)); push(pat(2));
        @(negedge meas_clk); win_size = 16'd5;
        repeat (10) @(negedge meas_clk);
        next_valid(s, ok);
        next_valid(s, ok);
        cmp("R8 old window", 80'(s), 80'd10);
        repeat (2) @(negedge meas_clk);
        win_size = 16'd9;
        next_valid(s, ok);
        cmp("R8 first after change whole", 80'((s == 21'd10) || (s == 21'd18)), 80'd1);
        next_valid(s, ok);
        cmp("R8 new window", 80'(s), 80'd18);
        next_valid(s, ok);
        cmp("R8 new window repeat", 80'(s), 80'd18);

        // R9, R10: N = 0 stops the accumulator
        @(negedge meas_clk); win_size = '0;
        repeat (30) @(negedge meas_clk);
        s0 = acc_sum; hits = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge meas_clk);
            if (acc_valid) hits++;
            if (acc_sum !== s0) hits++;
        end
        cmp("R9 no strobe while idle", 80'(hits), 80'd0);
        cmp("R10 sum held", 80'(acc_sum), 80'(s0));
        win_size = 16'd4;
        next_valid(s, ok);
        cmp("R9 restart strobe", 80'(ok), 80'd1);
        cmp("R9 restart total", 80'(s), 80'd8);

        summary();
    end
endmodule